// File: doc/BRIEF.md
# State-Gated Event Timer

This block is a timer whose compare events are qualified by a state variable that software sets up. A 32-bit count register runs either as one unified counter or as two independent 16-bit halves, called low and high. Each half has its own halt bit and its own 5-bit state value. Eight events each hold a match value, a 32-bit mask with one bit per state value, and a control word. An event fires when its selected counter half is running, the count equals the match value, and the mask bit for that half's current state is set.

A fired event can limit the counter (return it to zero), halt or restart a counter half, set or clear any of eight outputs, pulse the interrupt or DMA request line, and load or offset its half's state. By chaining events through state changes across counter periods, software builds a sequencer out of compare matches. A word-addressed register port configures the block. It answers every access in the same cycle and flags an error for a write that the halt rule forbids.

Register map (word addresses): 0x00 mode (bit 0 = unified), 0x01 halt (bit 0 low half, bit 1 high half), 0x02 count (bits 15:0 low, 31:16 high), 0x03 state (bits 4:0 low, 20:16 high). Event e uses base 0x10+4e: +0 state mask, +1 match, +2 control. Control bits: 0 compare half (0 low, 1 high), 1 limit, 2 halt, 3 run, 4 interrupt, 5 DMA, 6 state change enable, 7 state mode (0 load, 1 add), 12:8 state value or offset, 13 action half for limit/halt/run, 23:16 output set mask, 31:24 output clear mask.

Top module: `sgt_core`

## Requirements
- R1: After reset the count reads 0, both state values read 0, the halt register reads 3 (both halves halted), and the outputs, interrupt and DMA lines are 0.
- R2: An event fires only if its compare half is running, that half's count equals the match value (low 16 bits in split mode, all 32 bits in unified mode), and the mask bit indexed by that half's current state is 1. An event whose mask bit for the current state is 0 has no effect.
- R3: A fired event with state change enabled updates its compare half's state on the next clock: in load mode the state becomes the 5-bit value; in add mode the 5-bit value is added modulo 32. If several fired events change the same half's state in one cycle, the highest-numbered event sets it.
- R4: A fired limit event returns its action half's count to 0 on the next clock, and it takes priority over counting.
- R5: A fired halt event sets its action half's halt bit, and a fired run event clears it. When both act on one half in the same cycle, the halt bit ends up set. Event actions take priority over a bus write to the halt register in that cycle.
- R6: On the clock after a fire, each output bit named in any fired event's set mask becomes 1. Otherwise, each bit named in any clear mask becomes 0. The interrupt and DMA lines are high for exactly the one cycle after a cycle in which a fired event requests them.
- R7: A write to the count or state register is refused with the error signal high in that cycle and no change, unless the affected counter is halted: the low half in unified mode, both halves in split mode. Reads never give an error, and a refused write leaves the state value unchanged.
- R8: In split mode the two 16-bit halves count independently, and each wraps from 0xFFFF to 0 without touching the other half.
- R9: In unified mode the count is one 32-bit counter, carrying from bit 15 into bit 16. It runs on the low halt bit. All events use the low state and act on the low half, whatever their half-select bits say.
- R10: A state value that no event changes and no bus write touches stays at its value (0 from reset) while the counter runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Refused write, same cycle |
| out_o | output | 8 | Event-driven outputs |
| irq_o | output | 1 | Interrupt request pulse |
| dma_o | output | 1 | DMA request pulse |

## Verification
A wrong state value shows up as an event that fires or stays silent in the wrong counter period. This reaches the outputs and the halt and count registers one clock after the match cycle, and it is visible at once in the same-cycle read of the state register. The directed sequences end with a halt event, so the final count, state and outputs are fixed values that do not depend on sample timing. Throughout, the random phase compares every output and every read against a cycle-level model, so a divergence is caught in the cycle where it first appears at a port.

// File: rtl/sgt_pkg.sv
package sgt_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int ST_W    = 5;
  localparam int ST_N    = 1 << ST_W;
  localparam int OUT_N   = 8;
  localparam int CNT_W   = 32;
  localparam int HALF_W  = CNT_W / 2;

  localparam logic [ADDR_W-1:0] A_MODE  = 8'h00;
  localparam logic [ADDR_W-1:0] A_HALT  = 8'h01;
  localparam logic [ADDR_W-1:0] A_COUNT = 8'h02;
  localparam logic [ADDR_W-1:0] A_STATE = 8'h03;
  localparam logic [ADDR_W-1:0] A_EV    = 8'h10;

  typedef struct packed {
    logic [OUT_N-1:0] clr;
    logic [OUT_N-1:0] set;
    logic [1:0]       rsv;
    logic             act_h;
    logic [ST_W-1:0]  st_val;
    logic             st_add;
    logic             st_en;
    logic             dma;
    logic             irq;
    logic             run;
    logic             halt;
    logic             limit;
    logic             cmp_h;
  } ev_ctrl_t;
endpackage

// File: rtl/sgt_event.sv
module sgt_event
  import sgt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mask,
  input  logic             wr_match,
  input  logic             wr_ctrl,
  input  logic [BUS_W-1:0] wdata,
  input  logic             unify,
  input  logic [CNT_W-1:0] cnt,
  input  logic [ST_W-1:0]  st_l,
  input  logic [ST_W-1:0]  st_h,
  input  logic             run_l,
  input  logic             run_h,
  output logic [ST_N-1:0]  mask_q,
  output logic [CNT_W-1:0] match_q,
  output ev_ctrl_t         ctrl_q,
  output logic             fire
);
  logic [ST_N-1:0]  mask_d;
  logic [CNT_W-1:0] match_d;
  ev_ctrl_t         ctrl_d;
  logic             half;
  logic             hit;
  logic [ST_W-1:0]  st_cur;

  always_comb begin
    mask_d  = mask_q;
    match_d = match_q;
    ctrl_d  = ctrl_q;
    if (wr_mask)  mask_d  = wdata[ST_N-1:0];
    if (wr_match) match_d = wdata[CNT_W-1:0];
    if (wr_ctrl)  ctrl_d  = ev_ctrl_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      match_q <= '0;
      ctrl_q  <= '0;
    end else begin
      mask_q  <= mask_d;
      match_q <= match_d;
      ctrl_q  <= ctrl_d;
    end
  end

  always_comb begin
    half   = unify ? 1'b0 : ctrl_q.cmp_h;
    st_cur = half ? st_h : st_l;
    if (unify)
      hit = (cnt == match_q);
    else if (half)
      hit = (cnt[CNT_W-1:HALF_W] == match_q[HALF_W-1:0]);
    else
      hit = (cnt[HALF_W-1:0] == match_q[HALF_W-1:0]);
    fire = hit && (half ? run_h : run_l) && mask_q[st_cur];
  end
endmodule

// File: rtl/sgt_counter.sv
module sgt_counter
  import sgt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unify,
  input  logic             run_l,
  input  logic             run_h,
  input  logic             lim_l,
  input  logic             lim_h,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0]  cnt_d;
  logic [HALF_W-1:0] lo_d;
  logic [HALF_W-1:0] hi_d;

  always_comb begin
    lo_d = cnt_q[HALF_W-1:0];
    hi_d = cnt_q[CNT_W-1:HALF_W];
    if (wr)         lo_d = wdata[HALF_W-1:0];
    else if (lim_l) lo_d = '0;
    else if (run_l) lo_d = lo_d + 1'b1;
    if (wr)         hi_d = wdata[CNT_W-1:HALF_W];
    else if (lim_h) hi_d = '0;
    else if (run_h) hi_d = hi_d + 1'b1;
    if (unify) begin
      if (wr)         cnt_d = wdata;
      else if (lim_l) cnt_d = '0;
      else if (run_l) cnt_d = cnt_q + 1'b1;
      else            cnt_d = cnt_q;
    end else begin
      cnt_d = {hi_d, lo_d};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sgt_ctl.sv
module sgt_ctl
  import sgt_pkg::*;
#(
  parameter int NUM_EV = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  unify,
  input  logic [NUM_EV-1:0]     fire,
  input  ev_ctrl_t [NUM_EV-1:0] ev_ctrl,
  input  logic                  halt_wr,
  input  logic                  st_wr,
  input  logic [BUS_W-1:0]      wdata,
  output logic [1:0][ST_W-1:0]  st_q,
  output logic [1:0]            halt_q,
  output logic [1:0]            lim,
  output logic [1:0]            st_chg,
  output logic [OUT_N-1:0]      out_q,
  output logic                  irq_q,
  output logic                  dma_q
);
  logic [1:0][ST_W-1:0] st_d;
  logic [1:0][ST_W-1:0] st_new;
  logic [1:0]           halt_d;
  logic [1:0]           stp;
  logic [1:0]           sta;
  logic [OUT_N-1:0]     set_m;
  logic [OUT_N-1:0]     clr_m;
  logic                 irq_d;
  logic                 dma_d;
  logic [OUT_N-1:0]     out_d;
  logic                 ah;
  logic                 ch;

  always_comb begin
    lim = '0; stp = '0; sta = '0; st_chg = '0; st_new = st_q;
    set_m = '0; clr_m = '0; irq_d = 1'b0; dma_d = 1'b0;
    ah = 1'b0; ch = 1'b0;
    for (int e = 0; e < NUM_EV; e++) begin
      if (fire[e]) begin
        ah = unify ? 1'b0 : ev_ctrl[e].act_h;
        ch = unify ? 1'b0 : ev_ctrl[e].cmp_h;
        if (ev_ctrl[e].limit) lim[ah] = 1'b1;
        if (ev_ctrl[e].halt)  stp[ah] = 1'b1;
        if (ev_ctrl[e].run)   sta[ah] = 1'b1;
        irq_d = irq_d | ev_ctrl[e].irq;
        dma_d = dma_d | ev_ctrl[e].dma;
        set_m = set_m | ev_ctrl[e].set;
        clr_m = clr_m | ev_ctrl[e].clr;
        if (ev_ctrl[e].st_en) begin
          st_chg[ch] = 1'b1;
          st_new[ch] = ev_ctrl[e].st_add ? (st_q[ch] + ev_ctrl[e].st_val)
                                         : ev_ctrl[e].st_val;
        end
      end
    end
  end

  always_comb begin
    st_d   = st_q;
    halt_d = halt_q;
    if (st_wr) begin
      st_d[0] = wdata[ST_W-1:0];
      st_d[1] = wdata[16 +: ST_W];
    end
    if (halt_wr) halt_d = wdata[1:0];
    for (int h = 0; h < 2; h++) begin
      if (st_chg[h]) st_d[h] = st_new[h];
      if (stp[h])      halt_d[h] = 1'b1;
      else if (sta[h]) halt_d[h] = 1'b0;
    end
    out_d = (out_q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      halt_q <= 2'b11;
      out_q  <= '0;
      irq_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      halt_q <= halt_d;
      out_q  <= out_d;
      irq_q  <= irq_d;
      dma_q  <= dma_d;
    end
  end
endmodule

// File: rtl/sgt_core.sv
module sgt_core
  import sgt_pkg::*;
#(
  parameter int NUM_EV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_err,
  output logic [OUT_N-1:0]  out_o,
  output logic              irq_o,
  output logic              dma_o
);
  localparam int IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;
  localparam int EV_SPAN = 4 * NUM_EV;

  logic [1:0]                rs_q;
  logic                      rst_s_n;
  logic                      unify_q;
  logic                      unify_d;
  logic [CNT_W-1:0]          cnt_q;
  logic [1:0][ST_W-1:0]      st_q;
  logic [1:0]                halt_q;
  logic [1:0]                lim;
  logic [1:0]                st_chg;
  logic [NUM_EV-1:0]         fire;
  logic [NUM_EV-1:0][ST_N-1:0]  ev_mask;
  logic [NUM_EV-1:0][CNT_W-1:0] ev_match;
  ev_ctrl_t [NUM_EV-1:0]     ev_ctrl;
  logic                      wr;
  logic                      prot_ok;
  logic                      cnt_wr;
  logic                      st_wr;
  logic                      halt_wr;
  logic [ADDR_W-1:0]         ev_off;
  logic                      ev_hit;
  logic [IDX_W-1:0]          ev_idx;
  logic                      halt_l;
  logic                      lim_l;
  logic                      st_chg_l;
  logic [HALF_W-1:0]         cnt_l;
  logic [ST_W-1:0]           state_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  always_comb begin
    wr      = bus_en && bus_we;
    prot_ok = unify_q ? halt_q[0] : (halt_q[0] && halt_q[1]);
    cnt_wr  = wr && (bus_addr == A_COUNT) && prot_ok;
    st_wr   = wr && (bus_addr == A_STATE) && prot_ok;
    halt_wr = wr && (bus_addr == A_HALT);
    bus_err = wr && ((bus_addr == A_COUNT) || (bus_addr == A_STATE)) && !prot_ok;
    unify_d = (wr && (bus_addr == A_MODE)) ? bus_wdata[0] : unify_q;
    ev_off  = bus_addr - A_EV;
    ev_hit  = (bus_addr >= A_EV) && (int'(ev_off) < EV_SPAN);
    ev_idx  = ev_off[2 +: IDX_W];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) unify_q <= 1'b0;
    else          unify_q <= unify_d;
  end

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    logic sel;
    assign sel = wr && ev_hit && (int'(ev_idx) == e);
    sgt_event u_ev (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .wr_mask  (sel && (ev_off[1:0] == 2'd0)),
      .wr_match (sel && (ev_off[1:0] == 2'd1)),
      .wr_ctrl  (sel && (ev_off[1:0] == 2'd2)),
      .wdata    (bus_wdata),
      .unify    (unify_q),
      .cnt      (cnt_q),
      .st_l     (st_q[0]),
      .st_h     (st_q[1]),
      .run_l    (!halt_q[0]),
      .run_h    (!halt_q[1]),
      .mask_q   (ev_mask[e]),
      .match_q  (ev_match[e]),
      .ctrl_q   (ev_ctrl[e]),
      .fire     (fire[e])
    );
  end

  sgt_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .unify (unify_q),
    .run_l (!halt_q[0]),
    .run_h (!halt_q[1]),
    .lim_l (lim[0]),
    .lim_h (lim[1]),
    .wr    (cnt_wr),
    .wdata (bus_wdata),
    .cnt_q (cnt_q)
  );

  sgt_ctl #(.NUM_EV(NUM_EV)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .unify   (unify_q),
    .fire    (fire),
    .ev_ctrl (ev_ctrl),
    .halt_wr (halt_wr),
    .st_wr   (st_wr),
    .wdata   (bus_wdata),
    .st_q    (st_q),
    .halt_q  (halt_q),
    .lim     (lim),
    .st_chg  (st_chg),
    .out_q   (out_o),
    .irq_q   (irq_o),
    .dma_q   (dma_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_MODE)       bus_rdata[0] = unify_q;
    else if (bus_addr == A_HALT)  bus_rdata[1:0] = halt_q;
    else if (bus_addr == A_COUNT) bus_rdata = cnt_q;
    else if (bus_addr == A_STATE) begin
      bus_rdata[ST_W-1:0]  = st_q[0];
      bus_rdata[16 +: ST_W] = st_q[1];
    end else if (ev_hit) begin
      case (ev_off[1:0])
        2'd0:    bus_rdata[ST_N-1:0] = ev_mask[ev_idx];
        2'd1:    bus_rdata = ev_match[ev_idx];
        2'd2:    bus_rdata = ev_ctrl[ev_idx];
        default: bus_rdata = '0;
      endcase
    end
  end

  assign halt_l   = halt_q[0];
  assign lim_l    = lim[0];
  assign st_chg_l = st_chg[0];
  assign cnt_l    = cnt_q[HALF_W-1:0];
  assign state_l  = st_q[0];
endmodule

// File: rtl/sgt_core_chk.sv
module sgt_core_chk #(
  parameter int NUM_EV = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic              bus_err,
  input logic              irq_o,
  input logic [NUM_EV-1:0] fire,
  input logic              halt_l,
  input logic              halt_h,
  input logic              lim_l,
  input logic              cnt_wr,
  input logic [15:0]       cnt_l,
  input logic              st_chg_l,
  input logic              st_wr,
  input logic [4:0]        state_l
);
  AST_ERR_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_en && bus_we)); // R7
  AST_FIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire) |-> (!halt_l || !halt_h)); // R2
  AST_LIMIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_l && !cnt_wr) |=> (cnt_l == 16'h0)); // R4
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_l && !cnt_wr && !lim_l) |=> $stable(cnt_l)); // R8
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_chg_l && !st_wr) |=> $stable(state_l)); // R10
  AST_IRQ_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|fire)); // R6
endmodule

bind sgt_core sgt_core_chk #(.NUM_EV(NUM_EV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_err  (bus_err),
  .irq_o    (irq_o),
  .fire     (fire),
  .halt_l   (halt_l),
  .halt_h   (halt_q[1]),
  .lim_l    (lim_l),
  .cnt_wr   (cnt_wr),
  .cnt_l    (cnt_l),
  .st_chg_l (st_chg_l),
  .st_wr    (st_wr),
  .state_l  (state_l)
);

// File: tb/sgt_core_tb.sv
module sgt_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        bus_en;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [7:0]  out_o;
  logic        irq_o;
  logic        dma_o;

  int n_chk;
  int n_fail;

  logic        m_unify;
  logic        m_halt [2];
  logic [4:0]  m_st [2];
  logic [31:0] m_cnt;
  logic [31:0] m_mask [8];
  logic [31:0] m_match [8];
  logic [31:0] m_ctrl [8];
  logic [7:0]  m_out;
  logic        m_irq;
  logic        m_dma;

  sgt_core dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .out_o(out_o), .irq_o(irq_o), .dma_o(dma_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ev_a(input int e, input int sel);
    return 32'(16 + 4*e + sel);
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] clr, input logic [7:0] set,
      input logic acth, input logic [4:0] val, input logic add, input logic sten,
      input logic dma, input logic irq, input logic run, input logic halt,
      input logic limit, input logic cmph);
    return {clr, set, 2'b00, acth, val, add, sten, dma, irq, run, halt, limit, cmph};
  endfunction

  function automatic logic m_ok();
    return m_unify ? m_halt[0] : (m_halt[0] && m_halt[1]);
  endfunction

  function automatic logic m_err(input logic en, input logic we, input logic [7:0] a);
    return en && we && (a == 8'h02 || a == 8'h03) && !m_ok();
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int e;
    if (a == 8'h00) return {31'b0, m_unify};
    if (a == 8'h01) return {30'b0, m_halt[1], m_halt[0]};
    if (a == 8'h02) return m_cnt;
    if (a == 8'h03) return {11'b0, m_st[1], 11'b0, m_st[0]};
    if (a >= 8'h10 && a < 8'h30) begin
      e = (int'(a) - 16) / 4;
      case ((int'(a) - 16) % 4)
        0: return m_mask[e];
        1: return m_match[e];
        2: return m_ctrl[e];
        default: return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h01) return "R5";
    if (a == 8'h02) return "R8";
    if (a == 8'h03) return "R3";
    return "R2";
  endfunction

  task automatic m_step(input logic en, input logic we, input logic [7:0] a, input logic [31:0] d);
    logic [7:0]  fire;
    logic        lim [2];
    logic        stp [2];
    logic        sta [2];
    logic        chg [2];
    logic [4:0]  nst [2];
    logic [7:0]  setm, clrm;
    logic        irq, dma, wr, h, ah, hit;
    logic [31:0] c;
    logic [15:0] lo, hi;
    int          e;
    wr = en && we;
    setm = 0; clrm = 0; irq = 0; dma = 0;
    for (int k = 0; k < 2; k++) begin
      lim[k] = 0; stp[k] = 0; sta[k] = 0; chg[k] = 0; nst[k] = m_st[k];
    end
    for (int i = 0; i < 8; i++) begin
      c = m_ctrl[i];
      h = m_unify ? 1'b0 : c[0];
      if (m_unify) hit = (m_cnt == m_match[i]);
      else if (h)  hit = (m_cnt[31:16] == m_match[i][15:0]);
      else         hit = (m_cnt[15:0] == m_match[i][15:0]);
      fire[i] = hit && !m_halt[h] && m_mask[i][m_st[h]];
    end
    for (int i = 0; i < 8; i++) begin
      if (fire[i]) begin
        c = m_ctrl[i];
        h  = m_unify ? 1'b0 : c[0];
        ah = m_unify ? 1'b0 : c[13];
        if (c[1]) lim[ah] = 1;
        if (c[2]) stp[ah] = 1;
        if (c[3]) sta[ah] = 1;
        irq |= c[4]; dma |= c[5];
        setm |= c[23:16]; clrm |= c[31:24];
        if (c[6]) begin
          chg[h] = 1;
          nst[h] = c[7] ? (m_st[h] + c[12:8]) : c[12:8];
        end
      end
    end
    // counter
    if (m_unify) begin
      if (wr && a == 8'h02 && m_ok()) m_cnt = d;
      else if (lim[0])                m_cnt = 0;
      else if (!m_halt[0])            m_cnt = m_cnt + 1;
    end else begin
      lo = m_cnt[15:0]; hi = m_cnt[31:16];
      if (wr && a == 8'h02 && m_ok()) begin lo = d[15:0]; hi = d[31:16]; end
      else begin
        if (lim[0]) lo = 0; else if (!m_halt[0]) lo = lo + 1;
        if (lim[1]) hi = 0; else if (!m_halt[1]) hi = hi + 1;
      end
      m_cnt = {hi, lo};
    end
    if (wr && a == 8'h03 && m_ok()) begin m_st[0] = d[4:0]; m_st[1] = d[20:16]; end
    if (wr && a == 8'h01) begin m_halt[0] = d[0]; m_halt[1] = d[1]; end
    for (int k = 0; k < 2; k++) begin
      if (chg[k]) m_st[k] = nst[k];
      if (stp[k]) m_halt[k] = 1; else if (sta[k]) m_halt[k] = 0;
    end
    if (wr && a >= 8'h10 && a < 8'h30) begin
      e = (int'(a) - 16) / 4;
      case ((int'(a) - 16) % 4)
        0: m_mask[e] = d;
        1: m_match[e] = d;
        2: m_ctrl[e] = d;
        default: ;
      endcase
    end
    if (wr && a == 8'h00) m_unify = d[0];
    m_out = (m_out & ~clrm) | setm;
    m_irq = irq; m_dma = dma;
  endtask

  task automatic cyc(input logic en, input logic we, input logic [7:0] a, input logic [31:0] d);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    chk("R7", {31'b0, bus_err}, {31'b0, m_err(en, we, a)});
    if (en && !we) chk(tag_of(a), bus_rdata, m_read(a));
    @(posedge clk);
    m_step(en, we, a, d);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    chk("R6", {24'b0, out_o}, {24'b0, m_out});
    chk("R6", {31'b0, irq_o}, {31'b0, m_irq});
    chk("R6", {31'b0, dma_o}, {31'b0, m_dma});
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a[7:0], d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h0, 32'h0);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    cyc(1'b1, 1'b0, a, 32'h0);
  endtask

  task automatic err_chk(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    #1;
    chk("R7", {31'b0, bus_err}, 32'h1);
    cyc(1'b1, 1'b1, a, d);
  endtask

  task automatic clr_ev();
    for (int e = 0; e < 8; e++) begin
      wr(ev_a(e, 0), 32'h0);
      wr(ev_a(e, 2), 32'h0);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] ra;
    int         op;
    n_chk = 0; n_fail = 0;
    m_unify = 0; m_halt[0] = 1; m_halt[1] = 1; m_st[0] = 0; m_st[1] = 0;
    m_cnt = 0; m_out = 0; m_irq = 0; m_dma = 0;
    for (int e = 0; e < 8; e++) begin m_mask[e] = 0; m_match[e] = 0; m_ctrl[e] = 0; end
    bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(8'h01, 32'h3, "R1");
    rd_chk(8'h02, 32'h0, "R1");
    rd_chk(8'h03, 32'h0, "R1");
    chk("R1", {24'b0, out_o}, 32'h0);

    // R10 state stays 0 with no state-changing event
    wr(ev_a(0,0), 32'hFFFF_FFFF); wr(ev_a(0,1), 32'd5);
    wr(ev_a(0,2), mk(8'h00, 8'h01, 0, 5'd0, 0, 0, 0, 1, 0, 0, 1, 0));
    wr(32'h01, 32'h2); idle(30); wr(32'h01, 32'h3);
    rd_chk(8'h03, 32'h0, "R10");

    // R3 priority: highest-numbered event wins
    clr_ev(); wr(32'h02, 32'h0);
    wr(ev_a(0,0), 32'hFFFF_FFFF); wr(ev_a(0,1), 32'd3);
    wr(ev_a(0,2), mk(0, 0, 0, 5'd5, 0, 1, 0, 0, 0, 0, 0, 0));
    wr(ev_a(1,0), 32'hFFFF_FFFF); wr(ev_a(1,1), 32'd3);
    wr(ev_a(1,2), mk(0, 0, 0, 5'd9, 0, 1, 0, 0, 0, 1, 0, 0));
    wr(32'h01, 32'h2); idle(8);
    rd_chk(8'h03, 32'd9, "R3");
    rd_chk(8'h02, 32'd4, "R5");

    // R3 add mode wraps modulo 32
    clr_ev(); wr(32'h03, 32'd30); wr(32'h02, 32'd4);
    wr(ev_a(0,0), 32'hFFFF_FFFF); wr(ev_a(0,1), 32'd6);
    wr(ev_a(0,2), mk(0, 0, 0, 5'd3, 1, 1, 0, 0, 0, 1, 0, 0));
    wr(32'h01, 32'h2); idle(8);
    rd_chk(8'h03, 32'd1, "R3");
    rd_chk(8'h02, 32'd7, "R5");

    // R5 halt wins over run
    clr_ev();
    wr(ev_a(0,0), 32'hFFFF_FFFF); wr(ev_a(0,1), 32'd9);
    wr(ev_a(0,2), mk(0, 0, 0, 5'd0, 0, 0, 0, 0, 1, 1, 0, 0));
    wr(32'h01, 32'h2); idle(8);
    rd_chk(8'h01, 32'h3, "R5");
    rd_chk(8'h02, 32'd10, "R5");

    // R6 set wins over clear, then clear alone
    clr_ev();
    wr(ev_a(0,0), 32'hFFFF_FFFF); wr(ev_a(0,1), 32'd12);
    wr(ev_a(0,2), mk(8'h3C, 8'h0F, 0, 5'd0, 0, 0, 1, 1, 0, 1, 0, 0));
    wr(32'h01, 32'h2); idle(8);
    chk("R6", {24'b0, out_o}, 32'h0F);
    wr(ev_a(0,1), 32'd14);
    wr(ev_a(0,2), mk(8'h03, 8'h00, 0, 5'd0, 0, 0, 0, 0, 0, 1, 0, 0));
    wr(32'h01, 32'h2); idle(6);
    chk("R6", {24'b0, out_o}, 32'h0C);

    // R4 limit returns count to zero
    clr_ev(); wr(32'h02, 32'd18);
    wr(ev_a(0,0), 32'hFFFF_FFFF); wr(ev_a(0,1), 32'd20);
    wr(ev_a(0,2), mk(0, 0, 0, 5'd0, 0, 0, 0, 0, 0, 0, 1, 0));
    wr(ev_a(1,0), 32'hFFFF_FFFF); wr(ev_a(1,1), 32'd2);
    wr(ev_a(1,2), mk(0, 0, 0, 5'd0, 0, 0, 0, 0, 0, 1, 0, 0));
    wr(32'h01, 32'h2); idle(10);
    rd_chk(8'h02, 32'd3, "R4");

    // R2 event masked out in current state (state is 1)
    clr_ev(); wr(32'h02, 32'd3);
    wr(ev_a(0,0), 32'hFFFF_FFFD); wr(ev_a(0,1), 32'd5);
    wr(ev_a(0,2), mk(0, 8'h80, 0, 5'd0, 0, 0, 0, 0, 0, 1, 0, 0));
    wr(ev_a(1,0), 32'hFFFF_FFFF); wr(ev_a(1,1), 32'd8);
    wr(ev_a(1,2), mk(0, 0, 0, 5'd0, 0, 0, 0, 0, 0, 1, 0, 0));
    wr(32'h01, 32'h2); idle(10);
    chk("R2", {24'b0, out_o}, 32'h0C);
    rd_chk(8'h02, 32'd9, "R2");

    // R7 protected writes while running
    clr_ev(); wr(32'h01, 32'h2);
    err_chk(8'h02, 32'h1234);
    err_chk(8'h03, 32'h1F);
    cyc(1'b1, 1'b0, 8'h02, 32'h0);
    wr(32'h01, 32'h3);
    rd_chk(8'h03, 32'd1, "R7");

    // R8 split low half wraps without touching high half
    wr(32'h02, 32'h0005_FFFE); clr_ev();
    wr(ev_a(0,0), 32'hFFFF_FFFF); wr(ev_a(0,1), 32'd1);
    wr(ev_a(0,2), mk(0, 0, 0, 5'd0, 0, 0, 0, 0, 0, 1, 0, 0));
    wr(32'h01, 32'h2); idle(8);
    rd_chk(8'h02, 32'h0005_0002, "R8");

    // R9 unified carry, half selects ignored
    wr(32'h00, 32'h1); wr(32'h02, 32'h0000_FFFE); clr_ev();
    wr(ev_a(0,0), 32'hFFFF_FFFF); wr(ev_a(0,1), 32'h0001_0001);
    wr(ev_a(0,2), mk(0, 0, 1, 5'd7, 0, 1, 0, 0, 0, 1, 0, 1));
    wr(32'h01, 32'h2); idle(8);
    rd_chk(8'h02, 32'h0001_0002, "R9");
    rd_chk(8'h03, 32'd7, "R9");
    rd_chk(8'h01, 32'h3, "R9");
    wr(32'h00, 32'h0);

    // random phase against the model
    void'($urandom(32'd2024));
    for (int r = 0; r < 8; r++) begin
      wr(32'h01, 32'h3);
      wr(32'h00, {31'b0, 1'($urandom_range(0, 1))});
      for (int e = 0; e < 8; e++) begin
        wr(ev_a(e,0), $urandom | $urandom);
        wr(ev_a(e,1), $urandom_range(0, 24));
        wr(ev_a(e,2), $urandom);
      end
      wr(32'h02, {16'($urandom_range(0, 24)), 16'($urandom_range(0, 24))});
      wr(32'h03, $urandom);
      wr(32'h01, {30'b0, 2'($urandom_range(0, 3))});
      for (int i = 0; i < 250; i++) begin
        op = $urandom_range(0, 99);
        if (op < 60) begin
          ra = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 3)) : 8'($urandom_range(16, 47));
          cyc(1'b1, 1'b0, ra, 32'h0);
        end else if (op < 70) begin
          wr(32'h01, {30'b0, 2'($urandom_range(0, 3))});
        end else if (op < 80) begin
          wr(32'($urandom_range(2, 3)), {16'($urandom_range(0, 24)), 16'($urandom_range(0, 24))});
        end else begin
          idle(1);
        end
      end
    end
    finish_run();
  end
endmodule